// File: doc/BRIEF.md
# Accumulator and Extension Bit-Serial Shifter

This unit carries out the shift class of operations of a 16-bit accumulator machine on the accumulator (A) and its extension register (Q). A single-cycle `start` hands it a direction, a two-bit variant selector, the two-bit tag and the shift amount sources. The unit then moves the data one bit position per clock until the count is used up. For the left-and-count variants, it also stops as soon as the accumulator is normalized. It returns the new A, Q, carry and remaining count, and raises `done` for one cycle.

The shift amount comes from the instruction's own low six bits when the tag is zero. Otherwise it comes from the low six bits of the index register the tag selects, which the surrounding datapath presents on `xr_val`. The unit also reports the cost of the operation in base storage cycles plus extra steps, so a sequencer can account for execution time. Shifts exist only as short, direct instructions. A launch flagged as long-format or indirect is turned away without moving any data.

Top module: `acc_shift_unit`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` rises at the next clock and stays high until the clock at which `done` rises. `done` is a one-cycle pulse with `busy` low. A `start` seen while busy is ignored. From the accepting edge, `done` is high after exactly S+1 further clocks, where S is the number of positions actually moved.
- R2: Left, selector 00: A moves left by N with zeros entering bit 0. Carry becomes the last bit shifted out of A[15]. Q is unchanged.
- R3: Left, selector 10: the 32-bit pair {A,Q} (A high) moves left by N with zeros entering Q[0]. Carry becomes the last bit out of A[15].
- R4: Left, selectors 01 (A only) and 11 (pair) with a nonzero tag: shifting as in R2/R3 stops before any step where A[15] is 1. `count_out` returns the positions not performed (0 when all N were done). Carry is changed only by steps actually taken.
- R5: With tag 00, selectors 01 and 11 behave exactly as 00 and 10 (no early stop, `count_out` = 0).
- R6: N is `imm_field[5:0]` when tag = 00, else `xr_val[5:0]`. The other source has no effect.
- R7: Right, selector 00 or 01: A shifts right arithmetically by N, copying A[15] into vacated positions. Q and carry are unchanged.
- R8: Right, selector 10: {A,Q} shifts right arithmetically by N, with A[15] replicated. Carry is unchanged.
- R9: Right, selector 11: {A,Q} rotates right by N, with Q[0] entering A[15]. Carry is unchanged.
- R10: N = 0 leaves A, Q and carry equal to the launched values, with `done` one clock later.
- R11: At `done`, `stor_cycles` is 1 for A-only operations and 2 for pair and rotate operations. `extra_steps` is S-4 when S > 4, else 0.
- R12: A launch with `long_fmt` or `indirect` high moves nothing. It returns the launched A, Q and carry, and pulses `rejected` together with `done` one clock later, with `stor_cycles` = 0, `extra_steps` = 0 and `count_out` = 0.
- R13: While `rst_n` is low, `busy`, `done`, `rejected`, A, Q, carry and `count_out` are all zero, including when reset arrives in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted when idle |
| dir_left | input | 1 | 1 = left family, 0 = right family |
| modifier | input | 2 | Variant selector |
| tag | input | 2 | Tag field; 00 selects the immediate count |
| imm_field | input | 6 | Count carried in the instruction |
| xr_val | input | 16 | Contents of the selected index register |
| long_fmt | input | 1 | Launch uses the two-word format (illegal) |
| indirect | input | 1 | Launch requests indirect addressing (illegal) |
| a_in | input | 16 | Accumulator value at launch |
| q_in | input | 16 | Extension value at launch |
| carry_in | input | 1 | Carry indicator at launch |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rejected | output | 1 | Completion was a refusal |
| a_out | output | 16 | Resulting accumulator |
| q_out | output | 16 | Resulting extension |
| carry_out | output | 1 | Resulting carry |
| count_out | output | 6 | Positions not performed |
| stor_cycles | output | 2 | Base storage cycles charged |
| extra_steps | output | 6 | Extra steps charged beyond the base |

## Verification
The properties check on every cycle that `done` is a one-cycle pulse that ends each busy period, and that a start arriving mid-operation leaves the latched operation untouched. On every clock, they also check that right shifts never alter the carry and that arithmetic right shifts keep A[15]. A count variant must halt once A[15] is set, and a refusal always coincides with `done`. Only the bench's scenarios can show the actual bit patterns, the choice of count source, the tag-zero fallback, the exact latency and cost figures, and the reset state.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;

  // operation actually performed on the data path
  typedef enum logic [2:0] {
    SOP_LA  = 3'd0,  // left, accumulator only
    SOP_LAQ = 3'd1,  // left, accumulator:extension pair
    SOP_RA  = 3'd2,  // arithmetic right, accumulator only
    SOP_RAQ = 3'd3,  // arithmetic right, pair
    SOP_ROT = 3'd4   // rotate right through the pair
  } shop_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sst_e;

endpackage

// File: rtl/acc_shift_decode.sv
module acc_shift_decode
  import acc_shift_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 6
) (
  input  logic          dir_left,
  input  logic [1:0]    modifier,
  input  logic [1:0]    tag,
  input  logic [CW-1:0] imm_field,
  input  logic [W-1:0]  xr_val,
  input  logic          long_fmt,
  input  logic          indirect,
  output shop_e         op,
  output logic          cmode,
  output logic          pair,
  output logic          illegal,
  output logic [CW-1:0] count
);

  logic tag_zero;

  always_comb begin
    tag_zero = (tag == 2'b00);
    count    = tag_zero ? imm_field : xr_val[CW-1:0];
    illegal  = long_fmt | indirect;
    cmode    = 1'b0;
    if (dir_left) begin
      // bit 1 picks the pair, bit 0 asks for normalize-and-count
      op    = modifier[1] ? SOP_LAQ : SOP_LA;
      cmode = modifier[0] & ~tag_zero;
    end else begin
      unique case (modifier)
        2'b10:   op = SOP_RAQ;
        2'b11:   op = SOP_ROT;
        default: op = SOP_RA;
      endcase
    end
    pair = (op != SOP_LA) && (op != SOP_RA);
  end

endmodule

// File: rtl/acc_shift_step.sv
module acc_shift_step
  import acc_shift_pkg::*;
#(
  parameter int W = 16
) (
  input  shop_e        op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] q,
  input  logic         c,
  output logic [W-1:0] a_n,
  output logic [W-1:0] q_n,
  output logic         c_n
);

  always_comb begin
    a_n = a;
    q_n = q;
    c_n = c;
    unique case (op)
      SOP_LA:  {c_n, a_n}      = {a, 1'b0};
      SOP_LAQ: {c_n, a_n, q_n} = {a, q, 1'b0};
      SOP_RA:  a_n             = {a[W-1], a[W-1:1]};
      SOP_RAQ: {a_n, q_n}      = {a[W-1], a, q[W-1:1]};
      SOP_ROT: {a_n, q_n}      = {q[0], a, q[W-1:1]};
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_shift_ctrl.sv
module acc_shift_ctrl
  import acc_shift_pkg::*;
#(
  parameter int CW       = 6,
  parameter int FREE_POS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  shop_e         op_d,
  input  logic          cmode_d,
  input  logic          pair_d,
  input  logic          illegal_d,
  input  logic [CW-1:0] count_d,
  input  logic          a_msb,
  output logic          busy,
  output logic          done,
  output logic          rejected,
  output logic          load_en,
  output logic          shift_en,
  output shop_e         op_q,
  output logic          cmode_q,
  output logic [CW-1:0] rem_q,
  output logic [1:0]    stor_cycles,
  output logic [CW-1:0] extra_steps
);

  localparam logic [CW-1:0] FREE_V = CW'(FREE_POS);
  localparam logic [CW-1:0] ONE_V  = CW'(1);

  sst_e          st_q, st_n;
  logic [CW-1:0] rem_n, sh_q, sh_n;
  shop_e         op_n;
  logic          cmode_n, pair_q, pair_n, rej_q, rej_n, done_q, done_n;
  logic          stop;

  always_comb begin
    st_n     = st_q;
    rem_n    = rem_q;
    sh_n     = sh_q;
    op_n     = op_q;
    cmode_n  = cmode_q;
    pair_n   = pair_q;
    rej_n    = rej_q;
    done_n   = 1'b0;
    load_en  = 1'b0;
    shift_en = 1'b0;
    stop     = (rem_q == '0) || (cmode_q && a_msb);
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          st_n    = ST_RUN;
          op_n    = op_d;
          cmode_n = cmode_d & ~illegal_d;
          pair_n  = pair_d;
          rej_n   = illegal_d;
          rem_n   = illegal_d ? '0 : count_d;
          sh_n    = '0;
        end
      end
      ST_RUN: begin
        if (stop) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end else begin
          shift_en = 1'b1;
          rem_n    = rem_q - ONE_V;
          sh_n     = sh_q + ONE_V;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rem_q   <= '0;
      sh_q    <= '0;
      op_q    <= SOP_LA;
      cmode_q <= 1'b0;
      pair_q  <= 1'b0;
      rej_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      rem_q   <= rem_n;
      sh_q    <= sh_n;
      op_q    <= op_n;
      cmode_q <= cmode_n;
      pair_q  <= pair_n;
      rej_q   <= rej_n;
      done_q  <= done_n;
    end
  end

  always_comb begin
    busy        = (st_q == ST_RUN);
    done        = done_q;
    rejected    = done_q & rej_q;
    stor_cycles = rej_q ? 2'd0 : (pair_q ? 2'd2 : 2'd1);
    extra_steps = (sh_q > FREE_V) ? (sh_q - FREE_V) : '0;
  end

endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import acc_shift_pkg::*;
#(
  parameter int W        = 16,
  parameter int CW       = 6,
  parameter int FREE_POS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_left,
  input  logic [1:0]    modifier,
  input  logic [1:0]    tag,
  input  logic [CW-1:0] imm_field,
  input  logic [W-1:0]  xr_val,
  input  logic          long_fmt,
  input  logic          indirect,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  q_in,
  input  logic          carry_in,
  output logic          busy,
  output logic          done,
  output logic          rejected,
  output logic [W-1:0]  a_out,
  output logic [W-1:0]  q_out,
  output logic          carry_out,
  output logic [CW-1:0] count_out,
  output logic [1:0]    stor_cycles,
  output logic [CW-1:0] extra_steps
);

  shop_e         op_d, op_q;
  logic          cmode_d, cmode_q, pair_d, illegal_d;
  logic [CW-1:0] count_d;
  logic          load_en, shift_en;
  logic [W-1:0]  a_q, q_q, a_st, q_st, a_n, q_n;
  logic          c_q, c_st, c_n;

  acc_shift_decode #(.W(W), .CW(CW)) u_dec (
    .dir_left  (dir_left),
    .modifier  (modifier),
    .tag       (tag),
    .imm_field (imm_field),
    .xr_val    (xr_val),
    .long_fmt  (long_fmt),
    .indirect  (indirect),
    .op        (op_d),
    .cmode     (cmode_d),
    .pair      (pair_d),
    .illegal   (illegal_d),
    .count     (count_d)
  );

  acc_shift_ctrl #(.CW(CW), .FREE_POS(FREE_POS)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op_d        (op_d),
    .cmode_d     (cmode_d),
    .pair_d      (pair_d),
    .illegal_d   (illegal_d),
    .count_d     (count_d),
    .a_msb       (a_q[W-1]),
    .busy        (busy),
    .done        (done),
    .rejected    (rejected),
    .load_en     (load_en),
    .shift_en    (shift_en),
    .op_q        (op_q),
    .cmode_q     (cmode_q),
    .rem_q       (count_out),
    .stor_cycles (stor_cycles),
    .extra_steps (extra_steps)
  );

  acc_shift_step #(.W(W)) u_step (
    .op  (op_q),
    .a   (a_q),
    .q   (q_q),
    .c   (c_q),
    .a_n (a_st),
    .q_n (q_st),
    .c_n (c_st)
  );

  always_comb begin
    a_n = a_q;
    q_n = q_q;
    c_n = c_q;
    if (load_en) begin
      a_n = a_in;
      q_n = q_in;
      c_n = carry_in;
    end else if (shift_en) begin
      a_n = a_st;
      q_n = q_st;
      c_n = c_st;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      q_q <= '0;
      c_q <= 1'b0;
    end else if (load_en || shift_en) begin
      a_q <= a_n;
      q_q <= q_n;
      c_q <= c_n;
    end
  end

  assign a_out     = a_q;
  assign q_out     = q_q;
  assign carry_out = c_q;

endmodule

// File: rtl/acc_shift_unit_chk.sv
module acc_shift_unit_chk
  import acc_shift_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         rejected,
  input logic         carry_out,
  input logic [W-1:0] a_out,
  input logic [1:0]   stor_cycles,
  input shop_e        op_q,
  input logic         cmode_q
);

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_ends_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op_q));

  p_right_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op_q == SOP_RA || op_q == SOP_RAQ || op_q == SOP_ROT))
      |=> $stable(carry_out));

  p_sign_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op_q == SOP_RA || op_q == SOP_RAQ))
      |=> (a_out[W-1] == $past(a_out[W-1])));

  p_norm_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmode_q && a_out[W-1]) |=> !busy);

  p_reject_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> (done && stor_cycles == 2'd0));

  p_cost_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rejected) |-> (stor_cycles != 2'd0));

endmodule

bind acc_shift_unit acc_shift_unit_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .rejected    (rejected),
  .carry_out   (carry_out),
  .a_out       (a_out),
  .stor_cycles (stor_cycles),
  .op_q        (op_q),
  .cmode_q     (cmode_q)
);

// File: tb/acc_shift_unit_bench.sv
`timescale 1ns/1ps
module acc_shift_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, dir_left, long_fmt, indirect, carry_in;
  logic [1:0]  modifier, tag;
  logic [5:0]  imm_field;
  logic [15:0] xr_val, a_in, q_in;
  logic        busy, done, rejected, carry_out;
  logic [15:0] a_out, q_out;
  logic [5:0]  count_out, extra_steps;
  logic [1:0]  stor_cycles;

  int total = 0;
  int bad   = 0;
  logic busy_at_launch;

  always #2 clk = ~clk;

  acc_shift_unit u_acc_shift_unit (
    .clk, .rst_n, .start, .dir_left, .modifier, .tag, .imm_field, .xr_val,
    .long_fmt, .indirect, .a_in, .q_in, .carry_in, .busy, .done, .rejected,
    .a_out, .q_out, .carry_out, .count_out, .stor_cycles, .extra_steps
  );

  typedef struct packed {
    logic        dl;
    logic [1:0]  md;
    logic [1:0]  tg;
    logic [5:0]  im;
    logic [15:0] xv;
    logic [15:0] a;
    logic [15:0] q;
    logic        c;
    logic [15:0] ea;
    logic [15:0] eq;
    logic        ec;
    logic [5:0]  ecnt;
    logic [1:0]  es;
    logic [5:0]  ex;
    logic [5:0]  nsh;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    // R2: A left 4
    '{1'b1, 2'b00, 2'b00, 6'd4,  16'h0000, 16'h1234, 16'h5678, 1'b0, 16'h2340, 16'h5678, 1'b1, 6'd0,  2'd1, 6'd0,  6'd4},
    // R2 R11: A left 5, carry cleared
    '{1'b1, 2'b00, 2'b00, 6'd5,  16'h0000, 16'h8001, 16'hFFFF, 1'b1, 16'h0020, 16'hFFFF, 1'b0, 6'd0,  2'd1, 6'd1,  6'd5},
    // R3: pair left 8
    '{1'b1, 2'b10, 2'b00, 6'd8,  16'h0000, 16'h00FF, 16'hAB00, 1'b0, 16'hFFAB, 16'h0000, 1'b0, 6'd0,  2'd2, 6'd4,  6'd8},
    // R3 R6: pair left 16 from index, imm ignored
    '{1'b1, 2'b10, 2'b01, 6'h3F, 16'h0010, 16'h1234, 16'hABCD, 1'b0, 16'hABCD, 16'h0000, 1'b0, 6'd0,  2'd2, 6'd12, 6'd16},
    // R4: A count, stops after 5 of 9
    '{1'b1, 2'b01, 2'b01, 6'd0,  16'h0009, 16'h0400, 16'h1111, 1'b1, 16'h8000, 16'h1111, 1'b0, 6'd4,  2'd1, 6'd1,  6'd5},
    // R4 R6: pair count, index low bits 8, runs out
    '{1'b1, 2'b11, 2'b10, 6'd0,  16'hFFC8, 16'h0000, 16'h3000, 1'b0, 16'h0030, 16'h0000, 1'b0, 6'd0,  2'd2, 6'd4,  6'd8},
    // R4: pair count, stops after 17 of 20
    '{1'b1, 2'b11, 2'b11, 6'd0,  16'h0014, 16'h0000, 16'h4000, 1'b1, 16'h8000, 16'h0000, 1'b0, 6'd3,  2'd2, 6'd13, 6'd17},
    // R5: selector 01 with tag 00 is plain A shift
    '{1'b1, 2'b01, 2'b00, 6'd3,  16'h0000, 16'h8421, 16'h0F0F, 1'b1, 16'h2108, 16'h0F0F, 1'b0, 6'd0,  2'd1, 6'd0,  6'd3},
    // R5: selector 11 with tag 00 is plain pair shift
    '{1'b1, 2'b11, 2'b00, 6'd2,  16'h0000, 16'hC000, 16'h8001, 1'b0, 16'h0002, 16'h0004, 1'b1, 6'd0,  2'd2, 6'd0,  6'd2},
    // R7: A right arithmetic, selector 00
    '{1'b0, 2'b00, 2'b00, 6'd4,  16'h0000, 16'h8010, 16'h1234, 1'b1, 16'hF801, 16'h1234, 1'b1, 6'd0,  2'd1, 6'd0,  6'd4},
    // R7: A right, selector 01
    '{1'b0, 2'b01, 2'b00, 6'd6,  16'h0000, 16'h7F00, 16'hAAAA, 1'b0, 16'h01FC, 16'hAAAA, 1'b0, 6'd0,  2'd1, 6'd2,  6'd6},
    // R8: pair right arithmetic
    '{1'b0, 2'b10, 2'b00, 6'd8,  16'h0000, 16'h9234, 16'h5678, 1'b1, 16'hFF92, 16'h3456, 1'b1, 6'd0,  2'd2, 6'd4,  6'd8},
    // R9: rotate 4
    '{1'b0, 2'b11, 2'b00, 6'd4,  16'h0000, 16'h1234, 16'h5678, 1'b0, 16'h8123, 16'h4567, 1'b0, 6'd0,  2'd2, 6'd0,  6'd4},
    // R9 R11: rotate 32 from index
    '{1'b0, 2'b11, 2'b01, 6'd0,  16'h0020, 16'hDEAD, 16'hBEEF, 1'b1, 16'hDEAD, 16'hBEEF, 1'b1, 6'd0,  2'd2, 6'd28, 6'd32},
    // R10: A left count zero
    '{1'b1, 2'b00, 2'b00, 6'd0,  16'h0000, 16'hFFFF, 16'h0001, 1'b1, 16'hFFFF, 16'h0001, 1'b1, 6'd0,  2'd1, 6'd0,  6'd0},
    // R10: pair left count zero
    '{1'b1, 2'b10, 2'b00, 6'd0,  16'h0000, 16'h1357, 16'h2468, 1'b0, 16'h1357, 16'h2468, 1'b0, 6'd0,  2'd2, 6'd0,  6'd0},
    // R7 R11: A right 20 empties positive value
    '{1'b0, 2'b00, 2'b01, 6'd0,  16'h0014, 16'h4000, 16'h0000, 1'b1, 16'h0000, 16'h0000, 1'b1, 6'd0,  2'd1, 6'd16, 6'd20},
    // R4: count variant with A already normalized
    '{1'b1, 2'b11, 2'b01, 6'd0,  16'h000A, 16'h8000, 16'h0001, 1'b1, 16'h8000, 16'h0001, 1'b1, 6'd10, 2'd2, 6'd0,  6'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic dl, input logic [1:0] md, input logic [1:0] tg,
                        input logic [5:0] im, input logic [15:0] xv,
                        input logic lf, input logic ind,
                        input logic [15:0] av, input logic [15:0] qv,
                        input logic cv, output int cyc);
    @(negedge clk);
    dir_left = dl; modifier = md; tag = tg; imm_field = im; xr_val = xv;
    long_fmt = lf; indirect = ind; a_in = av; q_in = qv; carry_in = cv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_at_launch = busy;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    rst_n = 1'b0; start = 1'b0; dir_left = 1'b0; modifier = '0; tag = '0;
    imm_field = '0; xr_val = '0; long_fmt = 1'b0; indirect = 1'b0;
    a_in = '0; q_in = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(!busy && !done && !rejected, "R13", "status in reset", {busy, done, rejected}, 0);
    chk(a_out == 0 && q_out == 0 && !carry_out && count_out == 0, "R13", "data in reset",
        {a_out, q_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      launch(VT[i].dl, VT[i].md, VT[i].tg, VT[i].im, VT[i].xv, 1'b0, 1'b0,
             VT[i].a, VT[i].q, VT[i].c, cyc);
      chk(busy_at_launch, "R1", $sformatf("v%0d busy after start", i), busy_at_launch, 1);
      chk(cyc == int'(VT[i].nsh) + 1, "R1", $sformatf("v%0d latency", i), cyc, VT[i].nsh + 1);
      chk(a_out == VT[i].ea, "R2-9", $sformatf("v%0d A", i), a_out, VT[i].ea);
      chk(q_out == VT[i].eq, "R3/R8/R9", $sformatf("v%0d Q", i), q_out, VT[i].eq);
      chk(carry_out == VT[i].ec, "R2/R7", $sformatf("v%0d carry", i), carry_out, VT[i].ec);
      chk(count_out == VT[i].ecnt, "R4", $sformatf("v%0d count", i), count_out, VT[i].ecnt);
      chk(stor_cycles == VT[i].es && extra_steps == VT[i].ex, "R11",
          $sformatf("v%0d cost", i), {stor_cycles, extra_steps}, {VT[i].es, VT[i].ex});
      chk(!busy && !rejected, "R1", $sformatf("v%0d done state", i), {busy, rejected}, 0);
      @(negedge clk);
      chk(!done, "R1", $sformatf("v%0d done pulse", i), done, 0);
    end

    // R12: long format refused
    launch(1'b1, 2'b00, 2'b00, 6'd5, 16'h0, 1'b1, 1'b0, 16'h1234, 16'h0055, 1'b1, cyc);
    chk(cyc == 1 && rejected, "R12", "long fmt refused", {cyc[7:0], rejected}, {8'd1, 1'b1});
    chk(a_out == 16'h1234 && q_out == 16'h0055 && carry_out, "R12", "long fmt data",
        {a_out, q_out}, {16'h1234, 16'h0055});
    chk(stor_cycles == 0 && extra_steps == 0 && count_out == 0, "R12", "long fmt cost",
        {stor_cycles, extra_steps, count_out}, 0);
    // R12: indirect refused
    launch(1'b0, 2'b11, 2'b00, 6'd7, 16'h0, 1'b0, 1'b1, 16'hA5A5, 16'h0F0F, 1'b0, cyc);
    chk(cyc == 1 && rejected && a_out == 16'hA5A5 && q_out == 16'h0F0F, "R12",
        "indirect refused", {a_out, q_out}, {16'hA5A5, 16'h0F0F});

    // R1: start while busy is ignored
    @(negedge clk);
    dir_left = 1'b0; modifier = 2'b00; tag = 2'b00; imm_field = 6'd10; xr_val = '0;
    long_fmt = 1'b0; indirect = 1'b0; a_in = 16'h8000; q_in = 16'h0000; carry_in = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    dir_left = 1'b1; imm_field = 6'd1; a_in = 16'h0001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 3;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 11, "R1", "busy start latency", cyc, 11);
    chk(a_out == 16'hFFE0 && !carry_out, "R1", "busy start ignored", a_out, 16'hFFE0);
    @(negedge clk);
    chk(!busy && !done, "R1", "no relaunch", {busy, done}, 0);

    // R13: reset in the middle of an operation
    launch(1'b1, 2'b00, 2'b00, 6'd0, 16'h0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, cyc);
    @(negedge clk);
    dir_left = 1'b1; modifier = 2'b10; imm_field = 6'd30; a_in = 16'h1111; q_in = 16'h2222;
    carry_in = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!busy && !done && a_out == 0 && q_out == 0 && !carry_out && count_out == 0,
        "R13", "mid-run reset", {busy, a_out, q_out}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule